// File: doc/BRIEF.md
# Carrier Sweep Acquisition Controller

This controller runs next to a carrier-recovery loop for suppressed-carrier signals. While no carrier is present, it steps a signed frequency offset, which is added to the loop's numerically controlled oscillator, back and forth across a programmed detuning span. The step size per interval is capped so that the sweep never moves faster than the loop can follow. It also watches the loop's filtered in-phase and quadrature samples. When most of the energy has moved into the in-phase arm for long enough, the controller decides that the loop has captured the carrier.

After that decision the sweep freezes. The loop then gets a settling period with its wide acquisition gains still applied. After that period the controller selects the narrow tracking gains and keeps the offset constant. If the lock metric later stays low for several windows in a row, as after a cycle slip under heavy noise, the controller drops back to sweeping. The sweep resumes from the offset it held. Every state change happens on a cycle that carries a sample, so the gain select never switches between samples.

Top module: `acq_sweep_ctrl`

## Requirements
- R1: After reset `freq_ofs` is 0, `gain_narrow` is 0 and `locked` is 0. While `acq_en` is low, samples leave these values unchanged.
- R2: The sweep starts at offset 0 moving upward. It moves by the effective step after every `cfg_interval` samples. A step that would reach or pass +`cfg_range` or −`cfg_range` lands exactly on that end and reverses direction, so the offset never leaves [−range, +range].
- R3: The effective step is `cfg_step` limited to `MAX_STEP` (default 256). Successive offsets within the span never differ by more than `MAX_STEP`.
- R4: A window is `cfg_win` samples. Its metric is the sum of |I| − |Q| over the window, where I and Q are signed two's complement. A window counts as high when the metric is strictly greater than the signed `cfg_lock_thr`. While sweeping, `cfg_confirm` high windows in a row set `locked` to 1. At that point the offset freezes at the value produced by that last sample.
- R5: After lock is declared, `gain_narrow` stays 0 (wide gains) for `cfg_pullin` samples. It then becomes 1, which selects the narrow tracking gains.
- R6: While `gain_narrow` is 1, `freq_ofs` does not change.
- R7: A window counts as low when its metric is strictly less than the signed `cfg_unlock_thr`. After lock, `cfg_confirm` low windows in a row return the controller to sweeping: `locked` goes to 0 and `gain_narrow` goes to 0. The sweep then continues from the held offset. Low windows that are not consecutive do not cause a return.
- R8: State and outputs change only on clock edges where `smp_vld` is 1. This includes any change caused by `acq_en`.
- R9: A sample taken with `acq_en` low returns the controller to idle. One clock later `freq_ofs` is 0 and `locked` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acq_en | input | 1 | Run acquisition when high; return to idle when low |
| smp_vld | input | 1 | A filtered I/Q sample is present this cycle |
| smp_i | input | DW | Filtered in-phase sample, signed |
| smp_q | input | DW | Filtered quadrature sample, signed |
| cfg_range | input | FW-1 | Half-span of the sweep (the offset runs from −range to +range) |
| cfg_step | input | FW-1 | Requested offset step per interval |
| cfg_interval | input | ICW | Samples between sweep steps |
| cfg_win | input | WCW | Samples per lock-metric window |
| cfg_confirm | input | RCW | Consecutive windows needed for lock or loss |
| cfg_lock_thr | input | AW | Signed threshold for a high window |
| cfg_unlock_thr | input | AW | Signed threshold for a low window |
| cfg_pullin | input | PCW | Samples of settling with wide gains after lock |
| freq_ofs | output | FW | Signed frequency offset for the oscillator |
| gain_narrow | output | 1 | 1 selects tracking gains, 0 selects acquisition gains |
| locked | output | 1 | Lock has been declared |

## Verification
The bench drives sweeps that end exactly on a span edge, sweeps that overshoot one, and sweeps that cross both edges. A controller that wraps around, or that reverses one step late, shows up as a wrong offset. It requests a step larger than the cap to catch a missing rate limit. It feeds windows whose metric equals the lock threshold exactly, to catch a compare that is not strict. It also uses negative in-phase samples, to catch a missing magnitude. It interleaves low and middle windows during tracking to catch a loss counter that does not restart. It holds back samples around the pull-in handover and around a drop of `acq_en`; a controller that switched between samples would show a gain or offset change in those gaps.

// File: rtl/acq_pkg.sv
`timescale 1ns/1ps
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SWEEP  = 2'd1,
    ST_PULLIN = 2'd2,
    ST_TRACK  = 2'd3
  } acq_state_e;
endpackage

// File: rtl/acq_lock_detect.sv
`timescale 1ns/1ps
module acq_lock_detect #(
  parameter int DW  = 12,
  parameter int WCW = 8,
  parameter int RCW = 4,
  parameter int AW  = 22
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  vld,
  input  logic signed [DW-1:0]  smp_i,
  input  logic signed [DW-1:0]  smp_q,
  input  logic [WCW-1:0]        cfg_win,
  input  logic [RCW-1:0]        cfg_confirm,
  input  logic signed [AW-1:0]  lock_thr,
  input  logic signed [AW-1:0]  unlock_thr,
  output logic                  lock_cfm,
  output logic                  loss_cfm
);
  localparam int CW = DW + 2;

  // |a| - |b| with room for the most negative input
  function automatic logic signed [CW-1:0] mag_gap(input logic signed [DW-1:0] a,
                                                   input logic signed [DW-1:0] b);
    logic signed [CW-1:0] ma, mb;
    ma = CW'(a);
    mb = CW'(b);
    if (ma < 0) ma = -ma;
    if (mb < 0) mb = -mb;
    return ma - mb;
  endfunction

  // consecutive-window counter, saturating
  function automatic logic [RCW-1:0] run_next(input logic [RCW-1:0] r, input logic hit);
    if (!hit) return '0;
    if (&r) return r;
    return r + 1'b1;
  endfunction

  logic signed [AW-1:0] acc, gap_x, sum;
  logic [WCW-1:0]       wcnt, win_m1;
  logic [RCW-1:0]       hi_run, lo_run, conf_m1;
  logic                 win_end, hi_hit, lo_hit;

  assign gap_x   = AW'(mag_gap(smp_i, smp_q));
  assign sum     = acc + gap_x;
  assign win_m1  = (cfg_win == '0) ? '0 : cfg_win - 1'b1;
  assign conf_m1 = (cfg_confirm == '0) ? '0 : cfg_confirm - 1'b1;
  assign win_end = vld && (wcnt >= win_m1);
  assign hi_hit  = sum > lock_thr;
  assign lo_hit  = sum < unlock_thr;

  assign lock_cfm = win_end && hi_hit && (hi_run >= conf_m1);
  assign loss_cfm = win_end && lo_hit && (lo_run >= conf_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      wcnt   <= '0;
      hi_run <= '0;
      lo_run <= '0;
    end else if (clr) begin
      acc    <= '0;
      wcnt   <= '0;
      hi_run <= '0;
      lo_run <= '0;
    end else if (vld) begin
      if (win_end) begin
        acc    <= '0;
        wcnt   <= '0;
        hi_run <= run_next(hi_run, hi_hit);
        lo_run <= run_next(lo_run, lo_hit);
      end else begin
        acc  <= sum;
        wcnt <= wcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/acq_sweep_gen.sv
`timescale 1ns/1ps
module acq_sweep_gen #(
  parameter int FW       = 16,
  parameter int ICW      = 10,
  parameter int MAX_STEP = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic                 run,
  input  logic                 vld,
  input  logic [FW-2:0]        cfg_range,
  input  logic [FW-2:0]        cfg_step,
  input  logic [ICW-1:0]       cfg_interval,
  output logic signed [FW-1:0] ofs
);
  localparam int XW = FW + 2;
  localparam logic [FW-2:0] STEP_CAP = (FW-1)'(MAX_STEP);

  // one triangular step: returns {direction_up, new_offset}
  function automatic logic [FW:0] tri_next(input logic signed [FW-1:0] cur,
                                           input logic up,
                                           input logic [FW-2:0] stp,
                                           input logic [FW-2:0] rng);
    logic signed [XW-1:0] c, s, r, t;
    logic u;
    c = XW'(cur);
    s = $signed({3'b000, stp});
    r = $signed({3'b000, rng});
    u = up;
    if (up) begin
      t = c + s;
      if (t >= r) begin
        t = r;
        u = 1'b0;
      end
    end else begin
      t = c - s;
      if (t <= -r) begin
        t = -r;
        u = 1'b1;
      end
    end
    return {u, t[FW-1:0]};
  endfunction

  function automatic logic in_span(input logic signed [FW-1:0] o, input logic [FW-2:0] rng);
    logic signed [XW-1:0] ox, rx;
    ox = XW'(o);
    rx = $signed({3'b000, rng});
    return (ox <= rx) && (ox >= -rx);
  endfunction

  function automatic logic step_ok(input logic signed [FW-1:0] a, input logic signed [FW-1:0] b);
    logic signed [XW-1:0] d;
    d = XW'(a) - XW'(b);
    if (d < 0) d = -d;
    return d <= $signed({3'b000, STEP_CAP});
  endfunction

  logic            up;
  logic [ICW-1:0]  iv, iv_m1;
  logic [FW-2:0]   stp_eff;
  logic [FW:0]     nxt;
  logic            in_rng;

  assign stp_eff = (cfg_step > STEP_CAP) ? STEP_CAP : cfg_step;
  assign iv_m1   = (cfg_interval == '0) ? '0 : cfg_interval - 1'b1;
  assign nxt     = tri_next(ofs, up, stp_eff, cfg_range);
  assign in_rng  = in_span(ofs, cfg_range);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs <= '0;
      up  <= 1'b1;
      iv  <= '0;
    end else if (restart) begin
      ofs <= '0;
      up  <= 1'b1;
      iv  <= '0;
    end else if (!run) begin
      iv <= '0;
    end else if (vld) begin
      if (iv >= iv_m1) begin
        iv  <= '0;
        up  <= nxt[FW];
        ofs <= nxt[FW-1:0];
      end else begin
        iv <= iv + 1'b1;
      end
    end
  end

  // R3
  ofs_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !$past(restart) && $past(in_rng)) |-> step_ok(ofs, $past(ofs)))
    else $error("offset moved by more than the step cap");

  // R2
  ofs_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_rng) && $stable(cfg_range)) |-> in_rng)
    else $error("offset left the sweep span");
endmodule

// File: rtl/acq_fsm.sv
`timescale 1ns/1ps
module acq_fsm #(
  parameter int PCW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           vld,
  input  logic           lock_cfm,
  input  logic           loss_cfm,
  input  logic [PCW-1:0] cfg_pullin,
  output logic           sweep_run,
  output logic           sweep_restart,
  output logic           det_clr,
  output logic           gain_narrow,
  output logic           locked
);
  import acq_pkg::*;

  acq_state_e     st_q, st_n;
  logic [PCW-1:0] pcnt, p_m1;
  logic           pull_done;

  assign p_m1      = (cfg_pullin == '0) ? '0 : cfg_pullin - 1'b1;
  assign pull_done = pcnt >= p_m1;

  always_comb begin
    st_n = st_q;
    if (vld) begin
      if (!en) begin
        st_n = ST_IDLE;
      end else begin
        case (st_q)
          ST_IDLE:   st_n = ST_SWEEP;
          ST_SWEEP:  if (lock_cfm) st_n = ST_PULLIN;
          ST_PULLIN: begin
            if (loss_cfm)       st_n = ST_SWEEP;
            else if (pull_done) st_n = ST_TRACK;
          end
          ST_TRACK:  if (loss_cfm) st_n = ST_SWEEP;
          default:   st_n = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      pcnt <= '0;
    end else begin
      st_q <= st_n;
      if (st_q != ST_PULLIN) pcnt <= '0;
      else if (vld)          pcnt <= pcnt + 1'b1;
    end
  end

  assign sweep_run     = (st_q == ST_SWEEP);
  assign sweep_restart = (st_q == ST_IDLE);
  assign det_clr       = (st_n != st_q) || (st_q == ST_IDLE);
  assign gain_narrow   = (st_q == ST_TRACK);
  assign locked        = (st_q == ST_PULLIN) || (st_q == ST_TRACK);

  // R8
  gain_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_narrow != $past(gain_narrow)) |-> $past(vld))
    else $error("gain select changed between samples");

  // R4
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(st_q) == ST_SWEEP))
    else $error("lock declared outside the sweep");

  // R5
  narrow_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gain_narrow) |-> ($past(st_q) == ST_PULLIN))
    else $error("tracking gains selected without pull-in");
endmodule

// File: rtl/acq_sweep_ctrl.sv
`timescale 1ns/1ps
module acq_sweep_ctrl #(
  parameter int DW       = 12,
  parameter int FW       = 16,
  parameter int ICW      = 10,
  parameter int WCW      = 8,
  parameter int RCW      = 4,
  parameter int PCW      = 12,
  parameter int MAX_STEP = 256,
  localparam int AW      = DW + 2 + WCW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acq_en,
  input  logic                 smp_vld,
  input  logic signed [DW-1:0] smp_i,
  input  logic signed [DW-1:0] smp_q,
  input  logic [FW-2:0]        cfg_range,
  input  logic [FW-2:0]        cfg_step,
  input  logic [ICW-1:0]       cfg_interval,
  input  logic [WCW-1:0]       cfg_win,
  input  logic [RCW-1:0]       cfg_confirm,
  input  logic signed [AW-1:0] cfg_lock_thr,
  input  logic signed [AW-1:0] cfg_unlock_thr,
  input  logic [PCW-1:0]       cfg_pullin,
  output logic signed [FW-1:0] freq_ofs,
  output logic                 gain_narrow,
  output logic                 locked
);
  logic lock_cfm, loss_cfm;
  logic sweep_run, sweep_restart, det_clr;

  acq_lock_detect #(.DW(DW), .WCW(WCW), .RCW(RCW), .AW(AW)) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (det_clr),
    .vld        (smp_vld),
    .smp_i      (smp_i),
    .smp_q      (smp_q),
    .cfg_win    (cfg_win),
    .cfg_confirm(cfg_confirm),
    .lock_thr   (cfg_lock_thr),
    .unlock_thr (cfg_unlock_thr),
    .lock_cfm   (lock_cfm),
    .loss_cfm   (loss_cfm)
  );

  acq_sweep_gen #(.FW(FW), .ICW(ICW), .MAX_STEP(MAX_STEP)) u_swp (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (sweep_restart),
    .run         (sweep_run),
    .vld         (smp_vld),
    .cfg_range   (cfg_range),
    .cfg_step    (cfg_step),
    .cfg_interval(cfg_interval),
    .ofs         (freq_ofs)
  );

  acq_fsm #(.PCW(PCW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (acq_en),
    .vld          (smp_vld),
    .lock_cfm     (lock_cfm),
    .loss_cfm     (loss_cfm),
    .cfg_pullin   (cfg_pullin),
    .sweep_run    (sweep_run),
    .sweep_restart(sweep_restart),
    .det_clr      (det_clr),
    .gain_narrow  (gain_narrow),
    .locked       (locked)
  );

  // R6
  ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_narrow && $past(gain_narrow)) |-> $stable(freq_ofs))
    else $error("offset moved while tracking");
endmodule

// File: tb/acq_sweep_ctrl_tb.sv
`timescale 1ns/1ps
module acq_sweep_ctrl_tb;
  localparam int DW  = 12;
  localparam int FW  = 16;
  localparam int ICW = 10;
  localparam int WCW = 8;
  localparam int RCW = 4;
  localparam int PCW = 12;
  localparam int AW  = DW + 2 + WCW;

  // range, step, interval, sweep samples, expected offset   (R2, R3)
  localparam int NV = 9;
  localparam int VEC [NV][5] = '{
    '{100,   30, 1, 3,  90},
    '{100,   30, 1, 4, 100},
    '{100,   30, 1, 5,  70},
    '{100,   30, 2, 7,  90},
    '{ 50,   20, 1, 9, -30},
    '{5000, 1000, 1, 2, 512},
    '{ 10,   10, 1, 3, -10},
    '{ 10,   10, 1, 4,   0},
    '{100,   30, 3, 2,   0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acq_en = 1'b0;
  logic smp_vld = 1'b0;
  logic signed [DW-1:0] smp_i = '0;
  logic signed [DW-1:0] smp_q = '0;
  logic [FW-2:0]  cfg_range = '0;
  logic [FW-2:0]  cfg_step = '0;
  logic [ICW-1:0] cfg_interval = '0;
  logic [WCW-1:0] cfg_win = '0;
  logic [RCW-1:0] cfg_confirm = '0;
  logic signed [AW-1:0] cfg_lock_thr = '0;
  logic signed [AW-1:0] cfg_unlock_thr = '0;
  logic [PCW-1:0] cfg_pullin = '0;
  logic signed [FW-1:0] freq_ofs;
  logic gain_narrow, locked;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  acq_sweep_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .smp_vld(smp_vld),
    .smp_i(smp_i), .smp_q(smp_q), .cfg_range(cfg_range), .cfg_step(cfg_step),
    .cfg_interval(cfg_interval), .cfg_win(cfg_win), .cfg_confirm(cfg_confirm),
    .cfg_lock_thr(cfg_lock_thr), .cfg_unlock_thr(cfg_unlock_thr),
    .cfg_pullin(cfg_pullin), .freq_ofs(freq_ofs), .gain_narrow(gain_narrow),
    .locked(locked)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic smp(input int i, input int q);
    smp_vld = 1'b1;
    smp_i = DW'(i);
    smp_q = DW'(q);
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic smp_n(input int n, input int i, input int q);
    for (int k = 0; k < n; k++) smp(i, q);
  endtask

  task automatic gap(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 100000; k++) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    cfg_win = WCW'(4);
    cfg_confirm = RCW'(2);
    cfg_lock_thr = AW'(100);
    cfg_unlock_thr = -AW'(50);
    cfg_pullin = PCW'(5);
    gap(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, and samples while disabled change nothing
    chk("R1 reset freq_ofs", int'(freq_ofs), 0);
    chk("R1 reset gain_narrow", int'(gain_narrow), 0);
    chk("R1 reset locked", int'(locked), 0);
    cfg_range = 15'(100); cfg_step = 15'(30); cfg_interval = ICW'(1);
    smp_n(4, 50, 0);
    chk("R1 disabled freq_ofs", int'(freq_ofs), 0);
    chk("R1 disabled locked", int'(locked), 0);

    // R2 R3 sweep vectors, metric zero so no lock
    for (int v = 0; v < NV; v++) begin
      cfg_range = 15'(VEC[v][0]);
      cfg_step = 15'(VEC[v][1]);
      cfg_interval = ICW'(VEC[v][2]);
      acq_en = 1'b0;
      smp(0, 0);
      acq_en = 1'b1;
      smp(0, 0);
      smp_n(VEC[v][3], 0, 0);
      chk($sformatf("R2 R3 sweep vector %0d freq_ofs", v), int'(freq_ofs), VEC[v][4]);
    end

    // R4 metric equal to threshold is not high
    cfg_range = 15'(1000); cfg_step = 15'(10); cfg_interval = ICW'(1);
    acq_en = 1'b0; smp(0, 0);
    acq_en = 1'b1; smp(0, 0);
    smp_n(12, 25, 0);
    chk("R4 equal threshold no lock", int'(locked), 0);
    chk("R4 equal threshold sweep continues", int'(freq_ofs), 120);

    // R4 lock after two high windows, negative I counted by magnitude
    acq_en = 1'b0; smp(0, 0);
    acq_en = 1'b1; smp(0, 0);
    for (int k = 0; k < 7; k++) smp((k % 2) ? -50 : 50, 0);
    chk("R4 no lock before second window", int'(locked), 0);
    chk("R4 sweep before lock", int'(freq_ofs), 70);
    smp(-50, 0);
    chk("R4 locked after second window", int'(locked), 1);
    chk("R4 offset frozen value", int'(freq_ofs), 80);
    chk("R5 wide gains at lock", int'(gain_narrow), 0);

    // R5 pull-in with a sample gap (R8)
    smp_n(4, 50, 0);
    chk("R5 still wide after 4 samples", int'(gain_narrow), 0);
    chk("R4 offset held in pull-in", int'(freq_ofs), 80);
    gap(10);
    chk("R8 no gain change without sample", int'(gain_narrow), 0);
    smp(50, 0);
    chk("R5 narrow after pull-in", int'(gain_narrow), 1);
    chk("R5 locked in track", int'(locked), 1);

    // R6 offset held while tracking
    smp_n(20, 50, 0);
    chk("R6 offset held in track", int'(freq_ofs), 80);

    // R7 non-consecutive low windows keep lock
    smp_n(4, 0, 50);
    smp_n(4, 10, 0);
    smp_n(4, 0, 50);
    chk("R7 non-consecutive low keeps lock", int'(locked), 1);
    chk("R7 non-consecutive low keeps gains", int'(gain_narrow), 1);
    smp_n(3, 0, 50);
    chk("R7 no loss mid window", int'(locked), 1);
    smp(0, 50);
    chk("R7 loss clears locked", int'(locked), 0);
    chk("R7 loss restores wide gains", int'(gain_narrow), 0);
    chk("R7 held offset at loss", int'(freq_ofs), 80);
    smp(0, 0);
    chk("R7 sweep resumes from held offset", int'(freq_ofs), 90);

    // R8 R9 disable acts only on a sample
    acq_en = 1'b0;
    gap(3);
    chk("R8 disable without sample keeps offset", int'(freq_ofs), 90);
    smp(0, 0);
    gap(1);
    chk("R9 idle offset zero", int'(freq_ofs), 0);
    chk("R9 idle not locked", int'(locked), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule